// File: doc/BRIEF.md
# Configuration Write Synchronization Busy Tracker

This block sits between a fast bus clock domain and a slower converter core clock domain. It tracks writes to twelve configuration registers as they cross from the bus domain into the core domain. An accepted write to a tracked register saves the written value in a bus-side holding register and toggles a request line. The request passes through a two-flop synchronizer into the core domain. The core domain captures the held value there, then sends an acknowledge toggle back through a second two-flop synchronizer. Each register has its own busy flag. The flag is raised in the cycle the write is accepted and cleared once the acknowledge has returned.

The twelve flags form the low bits of a read-only 32-bit status word that software polls. A write aimed at a register that is still busy is stalled with a wait signal. It is accepted once the earlier transfer has finished. Two extra conditions affect the software-trigger flag only:

- Client mode always masks that flag to zero.
- A pulse signalling wake-up from standby raises that flag. The block then runs a dummy round trip that delivers no data, and the flag clears when that round trip ends.

When a soft-reset transfer completes, every busy flag is cleared.

Top module: `sbt_busy_tracker`

## Requirements
- R1: After bus reset the status word is all zeros and `wr_wait` is low.
- R2: Status bit i belongs to the register with select value i: 0 soft reset, 1 enable, 2 input routing, 3 secondary control, 4 reference, 5 averaging, 6 sample time, 7 window low, 8 window high, 9 gain trim, 10 offset trim, 11 software trigger. A write is accepted at a rising bus clock edge where `wr_en` is high and `wr_wait` is low. Bit i reads 1 immediately after the edge that accepts a write to register i.
- R3: A busy bit falls only after the core domain has captured the written value, except when a soft-reset completion clears it (R10).
- R4: The core domain applies each accepted write exactly once, using the written data. For one core clock cycle it drives `core_stb[i]` high and presents the value on slice i of `core_value`.
- R5: A write to a register whose transfer is still in flight holds `wr_wait` high. It is not accepted until the earlier transfer finishes, and then it delivers its own data.
- R6: Select values 12 to 15 are ignored. They raise no wait and set no busy bit. Status bits 31 to 12 always read zero.
- R7: While `client_mode` is high, status bit 11 reads zero.
- R8: A `standby_wake` pulse sets status bit 11 at the next bus edge.
- R9: A busy bit raised by wake-up clears after one dummy round trip, and the dummy round trip produces no `core_stb` pulse.
- R10: When the soft-reset transfer completes, all twelve busy bits read zero in the same cycle that bit 0 falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Bus-domain reset, active low |
| cclk | input | 1 | Core clock |
| crst_n | input | 1 | Core-domain reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 4 | Register select |
| wr_data | input | DW | Write data |
| wr_wait | output | 1 | Stall: selected register still busy |
| client_mode | input | 1 | Masks the software-trigger busy bit |
| standby_wake | input | 1 | One-cycle wake-from-standby pulse |
| status | output | 32 | Busy status word |
| core_stb | output | 12 | Core-domain capture strobes, one per register |
| core_value | output | 12*DW | Captured values, slice i for register i |

## Verification
A request or acknowledge toggle stuck at the wrong phase shows up at the ports in one of two ways. Either a busy bit never falls, or it falls before the matching `core_stb` pulse. Both are seen within one round trip, which is a few core cycles. If the holding register were allowed to change during a transfer, `core_value` would show the wrong data at the strobe. If wait gating were missing, a second write would be accepted while its bit is still high. That would produce an extra or an early strobe, or lose the first value. A wrong client mask, wrong wake handling or wrong soft-reset clearing is visible on the status word within one bus cycle of the event that should cause it.

// File: rtl/sbt_pkg.sv
`timescale 1ns/1ps
package sbt_pkg;
  localparam int NREG     = 12;
  localparam int SEL_W    = 4;
  localparam int STATUS_W = 32;

  typedef enum logic [SEL_W-1:0] {
    REG_SRST    = 4'd0,
    REG_EN      = 4'd1,
    REG_INROUTE = 4'd2,
    REG_CTL2    = 4'd3,
    REG_REF     = 4'd4,
    REG_AVG     = 4'd5,
    REG_SAMP    = 4'd6,
    REG_WLO     = 4'd7,
    REG_WHI     = 4'd8,
    REG_GAIN    = 4'd9,
    REG_OFFS    = 4'd10,
    REG_TRIG    = 4'd11
  } reg_id_e;

  // One-hot decode of a register select; out-of-range selects decode to zero.
  function automatic logic [NREG-1:0] sel_mask(input logic [SEL_W-1:0] sel);
    logic [NREG-1:0] m;
    for (int i = 0; i < NREG; i++) m[i] = (int'(sel) == i);
    return m;
  endfunction

  // Status word: busy flags in the low bits, trigger bit masked in client mode.
  function automatic logic [STATUS_W-1:0] pack_status(input logic [NREG-1:0] busy,
                                                      input logic client);
    logic [STATUS_W-1:0] s;
    s = '0;
    s[NREG-1:0] = busy;
    if (client) s[REG_TRIG] = 1'b0;
    return s;
  endfunction
endpackage

// File: rtl/sbt_sync2.sv
`timescale 1ns/1ps
module sbt_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      q      <= 1'b0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/sbt_channel.sv
`timescale 1ns/1ps
module sbt_channel #(
  parameter int DW = 16
) (
  input  logic          bclk,
  input  logic          brst_n,
  input  logic          start,
  input  logic          dummy,
  input  logic [DW-1:0] wdata,
  input  logic          clr_all,
  input  logic          force_set,
  output logic          busy,
  output logic          inflight,
  input  logic          cclk,
  input  logic          crst_n,
  output logic          core_stb,
  output logic [DW-1:0] core_val
);
  // bus side
  logic          req_q, dummy_q, busy_q, ack_s;
  logic [DW-1:0] hold_q;
  logic          done_w;

  assign inflight = req_q ^ ack_s;
  assign done_w   = busy_q & ~inflight;
  assign busy     = busy_q;

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      req_q   <= 1'b0;
      dummy_q <= 1'b0;
      hold_q  <= '0;
    end else if (start) begin
      req_q   <= ~req_q;
      dummy_q <= dummy;
      if (!dummy) hold_q <= wdata;
    end
  end

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n)                  busy_q <= 1'b0;
    else if (start || force_set)  busy_q <= 1'b1;
    else if (done_w || clr_all)   busy_q <= 1'b0;
  end

  // core side
  logic req_s, seen_q, cap_w;
  sbt_sync2 u_req_sync (.clk(cclk), .rst_n(crst_n), .d(req_q), .q(req_s));
  assign cap_w = req_s ^ seen_q;

  always_ff @(posedge cclk or negedge crst_n) begin
    if (!crst_n) begin
      seen_q   <= 1'b0;
      core_stb <= 1'b0;
      core_val <= '0;
    end else begin
      core_stb <= cap_w & ~dummy_q;
      if (cap_w) begin
        seen_q <= req_s;
        if (!dummy_q) core_val <= hold_q;
      end
    end
  end

  sbt_sync2 u_ack_sync (.clk(bclk), .rst_n(brst_n), .d(seen_q), .q(ack_s));

  p_busy_after_start_r2: assert property (@(posedge bclk) disable iff (!brst_n)
    start |=> busy_q);
  p_req_frozen_r5: assert property (@(posedge bclk) disable iff (!brst_n)
    inflight |=> $stable(req_q));
  p_hold_frozen_r4: assert property (@(posedge bclk) disable iff (!brst_n)
    inflight |=> $stable(hold_q));
  p_stb_single_r4: assert property (@(posedge cclk) disable iff (!crst_n)
    core_stb |=> !core_stb);
endmodule

// File: rtl/sbt_busy_tracker.sv
`timescale 1ns/1ps
module sbt_busy_tracker
  import sbt_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                  bclk,
  input  logic                  brst_n,
  input  logic                  cclk,
  input  logic                  crst_n,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [DW-1:0]         wr_data,
  output logic                  wr_wait,
  input  logic                  client_mode,
  input  logic                  standby_wake,
  output logic [STATUS_W-1:0]   status,
  output logic [NREG-1:0]       core_stb,
  output logic [NREG*DW-1:0]    core_value
);
  logic [NREG-1:0] wr_mask_w, busy_w, inflight_w, start_w, dummy_w, force_w;
  logic            blocked_w, srst_done_w, wake_start_w;

  assign wr_mask_w  = wr_en ? sel_mask(wr_sel) : '0;
  assign blocked_w  = |(wr_mask_w & (busy_w | inflight_w));
  assign wr_wait    = blocked_w;

  assign wake_start_w = standby_wake & ~busy_w[REG_TRIG] & ~inflight_w[REG_TRIG]
                        & ~(wr_mask_w[REG_TRIG] & ~blocked_w);

  always_comb begin
    start_w = blocked_w ? '0 : wr_mask_w;
    dummy_w = '0;
    force_w = '0;
    force_w[REG_TRIG] = standby_wake;
    if (wake_start_w) begin
      start_w[REG_TRIG] = 1'b1;
      dummy_w[REG_TRIG] = 1'b1;
    end
  end

  assign srst_done_w = busy_w[REG_SRST] & ~inflight_w[REG_SRST];

  for (genvar g = 0; g < NREG; g++) begin : g_ch
    sbt_channel #(.DW(DW)) u_ch (
      .bclk      (bclk),
      .brst_n    (brst_n),
      .start     (start_w[g]),
      .dummy     (dummy_w[g]),
      .wdata     (wr_data),
      .clr_all   (srst_done_w),
      .force_set (force_w[g]),
      .busy      (busy_w[g]),
      .inflight  (inflight_w[g]),
      .cclk      (cclk),
      .crst_n    (crst_n),
      .core_stb  (core_stb[g]),
      .core_val  (core_value[g*DW +: DW])
    );
  end

  assign status = pack_status(busy_w, client_mode);

  p_wait_busy_r5: assert property (@(posedge bclk) disable iff (!brst_n)
    (|(wr_mask_w & busy_w)) |-> wr_wait);
  p_client_mask_r7: assert property (@(posedge bclk) disable iff (!brst_n)
    client_mode |-> !status[REG_TRIG]);
  p_wake_set_r8: assert property (@(posedge bclk) disable iff (!brst_n)
    standby_wake |=> busy_w[REG_TRIG]);
  p_srst_clears_r10: assert property (@(posedge bclk) disable iff (!brst_n)
    (srst_done_w && start_w == '0 && !standby_wake) |=> busy_w == '0);
endmodule

// File: tb/sbt_busy_tracker_test.sv
`timescale 1ns/1ps
module sbt_busy_tracker_test;
  localparam int DW = 16;
  localparam int NR = 12;

  logic bclk = 0, cclk = 0, brst_n = 0, crst_n = 0;
  logic wr_en = 0, client_mode = 0, standby_wake = 0;
  logic [3:0] wr_sel = 0;
  logic [DW-1:0] wr_data = 0;
  logic wr_wait;
  logic [31:0] status;
  logic [NR-1:0] core_stb;
  logic [NR*DW-1:0] core_value;

  sbt_busy_tracker #(.DW(DW)) uut (
    .bclk(bclk), .brst_n(brst_n), .cclk(cclk), .crst_n(crst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .wr_wait(wr_wait),
    .client_mode(client_mode), .standby_wake(standby_wake), .status(status),
    .core_stb(core_stb), .core_value(core_value));

  always #10 bclk = ~bclk;
  initial begin
    int n;
    real hp;
    n = 0;
    forever begin
      hp = 17.3 + ((n * 7) % 13);
      #(hp) cclk = ~cclk;
      n++;
    end
  end

  typedef struct packed { logic [3:0] sel; logic [DW-1:0] val; } exp_t;
  exp_t sbq[$];
  int checks = 0, errors = 0;
  bit captured [NR];
  bit wake_pending = 0;
  int r10_seen = 0, r9_seen = 0;
  logic [NR-1:0] prev_st = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // driver: performs a write and pushes the expected core-side item
  task automatic do_write(input logic [3:0] sel, input logic [DW-1:0] d,
                          output bit waited);
    waited = 0;
    @(negedge bclk);
    wr_en = 1; wr_sel = sel; wr_data = d;
    #1;
    while (wr_wait) begin
      waited = 1;
      @(negedge bclk);
      #1;
    end
    if (sel < NR) captured[sel] = 0;
    @(posedge bclk);
    @(negedge bclk);
    wr_en = 0;
    if (sel < NR) sbq.push_back('{sel: sel, val: d});
  endtask

  task automatic settle();
    repeat (80) @(negedge bclk);
  endtask

  // monitor: core-domain captures popped against the scoreboard
  always @(negedge cclk) if (crst_n) begin
    for (int k = 0; k < NR; k++) if (core_stb[k]) begin
      int idx;
      idx = -1;
      for (int i = 0; i < sbq.size(); i++)
        if (idx < 0 && sbq[i].sel == k[3:0]) idx = i;
      if (idx < 0) chk(0, "R4/R9 unexpected strobe", k, 32'hFFFF);
      else begin
        chk(core_value[k*DW +: DW] == sbq[idx].val, "R4 captured value",
            core_value[k*DW +: DW], sbq[idx].val);
        sbq.delete(idx);
        captured[k] = 1;
      end
    end
  end

  // busy-fall checker on the bus side
  always @(negedge bclk) begin
    if (!brst_n) prev_st = '0;
    else begin
      logic [NR-1:0] cur;
      cur = status[NR-1:0];
      if (prev_st[0] && !cur[0]) begin
        chk(cur == '0, "R10 all busy cleared", cur, 0);
        r10_seen++;
      end
      for (int k = 0; k < NR; k++) if (prev_st[k] && !cur[k]) begin
        if (k == NR-1 && wake_pending) begin
          wake_pending = 0;
          r9_seen++;
        end else if (k != 0 && prev_st[0] && !cur[0]) begin
          // cleared by soft-reset completion (R10)
        end else chk(captured[k], "R3 fall after capture", 0, 1);
      end
      prev_st = cur;
    end
  end

  initial begin
    bit w;
    repeat (3) @(negedge bclk);
    #1;
    chk(status == 0, "R1 reset status", status, 0);
    chk(!wr_wait, "R1 reset wait", wr_wait, 0);
    brst_n = 1; crst_n = 1;
    repeat (3) @(negedge bclk);

    // R2/R3/R4: every non-reset register, back to back
    for (int k = 1; k < NR; k++) begin
      do_write(k[3:0], 16'hA000 + 16'(k * 37), w);
      chk(status[k], "R2 busy on accept", status, 32'(1) << k);
    end
    settle();
    chk(status == 0, "R3 all busy cleared", status, 0);

    // R5: second write to a busy register waits
    do_write(4'd4, 16'h1234, w);
    chk(status[4], "R2 busy reg4", status, 32'h10);
    do_write(4'd4, 16'h5678, w);
    chk(w, "R5 wait on busy", w, 1);
    chk(status[4], "R5 busy after second accept", status, 32'h10);
    settle();

    // R6: out-of-range select ignored
    do_write(4'd13, 16'hDEAD, w);
    chk(!w, "R6 no wait", w, 0);
    chk(status == 0, "R6 no busy", status, 0);
    repeat (30) @(negedge bclk);
    chk(status == 0, "R6 still idle", status, 0);

    // R7: client mode masks trigger bit
    client_mode = 1;
    do_write(4'd11, 16'h0BEE, w);
    chk(status[11] == 0, "R7 trigger masked", status, 0);
    settle();
    client_mode = 0;

    // R8/R9: wake from standby
    @(negedge bclk);
    standby_wake = 1; wake_pending = 1;
    @(negedge bclk);
    standby_wake = 0;
    chk(status[11], "R8 wake sets trigger", status, 32'h800);
    settle();
    chk(!wake_pending && r9_seen == 1, "R9 wake flag cleared", r9_seen, 1);

    // R10: soft reset clears everything on completion
    do_write(4'd0, 16'h0001, w);
    do_write(4'd2, 16'h2222, w);
    settle();
    chk(r10_seen > 0, "R10 soft reset completion seen", r10_seen, 1);
    chk(status == 0, "R10 idle", status, 0);

    chk(sbq.size() == 0, "R4 all writes applied", sbq.size(), 0);
    chk(status[31:12] == 0, "R6 reserved zero", status, 0);
    finish_run();
  end
endmodule